// File: doc/BRIEF.md
# Primary Interrupt Aggregator

This block is the first stage of a two-stage interrupt tree. Up to eight secondary interrupt banks each present a request for host line 1 and, if they have one, a separate request for host line 2. The aggregator folds these into one status byte per host line, where bit n stands for bank n, and drives one active-low interrupt pin per line. A host reads the status byte of its own line to learn which bank to service next.

Each bank position is configured by parameter as absent, dual-line (separate requests per host line) or single-line (its one request is shown to both host lines). Status bits are live: they follow the bank requests one clock later and drop as soon as the bank stops requesting. A test register on the byte-wide register port forces status bits on both lines at once so that interrupt paths can be exercised without any bank activity.

Top module: `pih_aggregator`

## Requirements
- R1: While reset is held and after it is released with no requests, both status bytes and the test register read 0x00 and both interrupt pins are high.
- R2: One clock after a present bank n raises its line-1 request, bit n of the line-1 status byte (read at offset 0x01) is 1.
- R3: For a dual-line bank n, bit n of the line-2 status byte (read at offset 0x02) follows its line-2 request one clock later, independently of its line-1 request.
- R4: For a single-line bank, its line-1 request sets its bit in both status bytes, and its line-2 request input has no effect on either byte.
- R5: Bits of absent bank positions read 0 in both status bytes and in the test register, whatever their requests or test writes.
- R6: The line-1 pin is low exactly when the line-1 status byte is non-zero.
- R7: The line-2 pin is low exactly when the line-2 status byte is non-zero.
- R8: A write to offset 0x03 loads the test register (read back at 0x03); each 1 bit in it sets the matching bit in both status bytes one clock later, until a later write clears it.
- R9: Reads of any offset other than 0x01, 0x02 and 0x03 return 0x00, and writes to any offset other than 0x03 change no state.
- R10: When all requests and test bits drop, both status bytes return to 0x00 and both pins go high one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_req_l1 | input | NUM_BANKS | Per-bank requests aimed at host line 1 (sole request of single-line banks) |
| bank_req_l2 | input | NUM_BANKS | Per-bank requests aimed at host line 2 (used by dual-line banks only) |
| reg_addr | input | ADDR_W | Register offset |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the offset on reg_addr |
| host1_irq_n | output | 1 | Active-low interrupt for host line 1 |
| host2_irq_n | output | 1 | Active-low interrupt for host line 2 |

## Verification
The bench builds the block with eight bank positions, positions 6 and 7 absent, and bank 1 set as single-line while banks 0 and 2 to 5 are dual-line. That mix puts mirroring, independent line-2 requests and masking of absent positions all within reach in one build, including test writes that hit absent bits. The stimulus table walks combinations of requests and test bits, and directed steps cover reset, unmapped offsets and writes to read-only offsets.

// File: rtl/pih_pkg.sv
package pih_pkg;
   // Register offsets; the host software relies on these fixed positions.
   localparam int unsigned OFS_LINE1_STATUS = 1;
   localparam int unsigned OFS_LINE2_STATUS = 2;
   localparam int unsigned OFS_TEST_SET     = 3;
   localparam int unsigned NUM_HOST_LINES   = 2;
endpackage

// File: rtl/pih_line_map.sv
// Routes each bank's request pins onto the two host lines.
module pih_line_map #(
   parameter int unsigned            NB           = 8,
   parameter logic [NB-1:0]          PRESENT_MASK = '1,
   parameter logic [NB-1:0]          DUAL_MASK    = '1
) (
   input  logic [NB-1:0] req_l1,
   input  logic [NB-1:0] req_l2,
   output logic [NB-1:0] line1_o,
   output logic [NB-1:0] line2_o
);
   for (genvar b = 0; b < NB; b++) begin : g_bank
      if (!PRESENT_MASK[b]) begin : g_absent
         assign line1_o[b] = 1'b0;
         assign line2_o[b] = 1'b0;
      end else if (DUAL_MASK[b]) begin : g_dual
         assign line1_o[b] = req_l1[b];
         assign line2_o[b] = req_l2[b];
      end else begin : g_single
         assign line1_o[b] = req_l1[b];
         assign line2_o[b] = req_l1[b];
      end
   end
endmodule

// File: rtl/pih_status_reg.sv
// One host line: registered status view and its active-low pin.
module pih_status_reg #(
   parameter int unsigned NB = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] req,
   input  logic [NB-1:0] force_bits,
   output logic [NB-1:0] status,
   output logic          irq_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= req | force_bits;
   end

   assign irq_n = ~(|status);
endmodule

// File: rtl/pih_regport.sv
// Byte register port: test register storage and read multiplexer.
module pih_regport
   import pih_pkg::*;
#(
   parameter int unsigned   NB           = 8,
   parameter int unsigned   ADDR_W       = 8,
   parameter int unsigned   DATA_W       = 8,
   parameter logic [NB-1:0] PRESENT_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NB-1:0]     stat_l1,
   input  logic [NB-1:0]     stat_l2,
   output logic [NB-1:0]     test_q,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned PAD_W = DATA_W - NB;

   logic hit_l1, hit_l2, hit_test;
   assign hit_l1   = (addr == ADDR_W'(OFS_LINE1_STATUS));
   assign hit_l2   = (addr == ADDR_W'(OFS_LINE2_STATUS));
   assign hit_test = (addr == ADDR_W'(OFS_TEST_SET));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             test_q <= '0;
      else if (wr && hit_test) test_q <= wdata[NB-1:0] & PRESENT_MASK;
   end

   logic [NB-1:0] sel;
   always_comb begin
      sel = '0;
      if (hit_l1)   sel = stat_l1;
      if (hit_l2)   sel = stat_l2;
      if (hit_test) sel = test_q;
   end

   if (PAD_W > 0) begin : g_pad
      assign rdata = {{PAD_W{1'b0}}, sel};
   end else begin : g_nopad
      assign rdata = sel;
   end
endmodule

// File: rtl/pih_aggregator.sv
module pih_aggregator
   import pih_pkg::*;
#(
   parameter int unsigned          NUM_BANKS    = 8,
   parameter int unsigned          ADDR_W       = 8,
   parameter int unsigned          DATA_W       = 8,
   parameter logic [NUM_BANKS-1:0] PRESENT_MASK = 8'h3F,
   parameter logic [NUM_BANKS-1:0] DUAL_MASK    = 8'h3D
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] bank_req_l1,
   input  logic [NUM_BANKS-1:0] bank_req_l2,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_wr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic                 host1_irq_n,
   output logic                 host2_irq_n
);
   if (NUM_BANKS < 1 || NUM_BANKS > DATA_W) begin : g_bad_banks
      $error("NUM_BANKS must lie between 1 and DATA_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W too narrow for the test register offset");
   end

   logic [NUM_BANKS-1:0] line_req [NUM_HOST_LINES];
   logic [NUM_BANKS-1:0] line_stat [NUM_HOST_LINES];
   logic                 line_irq_n [NUM_HOST_LINES];
   logic [NUM_BANKS-1:0] test_q;

   pih_line_map #(
      .NB(NUM_BANKS), .PRESENT_MASK(PRESENT_MASK), .DUAL_MASK(DUAL_MASK)
   ) u_map (
      .req_l1(bank_req_l1), .req_l2(bank_req_l2),
      .line1_o(line_req[0]), .line2_o(line_req[1])
   );

   for (genvar l = 0; l < NUM_HOST_LINES; l++) begin : g_line
      pih_status_reg #(.NB(NUM_BANKS)) u_stat (
         .clk(clk), .rst_n(rst_n),
         .req(line_req[l]), .force_bits(test_q),
         .status(line_stat[l]), .irq_n(line_irq_n[l])
      );
   end

   pih_regport #(
      .NB(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRESENT_MASK(PRESENT_MASK)
   ) u_port (
      .clk(clk), .rst_n(rst_n),
      .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
      .stat_l1(line_stat[0]), .stat_l2(line_stat[1]),
      .test_q(test_q), .rdata(reg_rdata)
   );

   logic [NUM_BANKS-1:0] stat1_w, stat2_w;
   assign stat1_w     = line_stat[0];
   assign stat2_w     = line_stat[1];
   assign host1_irq_n = line_irq_n[0];
   assign host2_irq_n = line_irq_n[1];
endmodule

// File: rtl/pih_aggregator_chk.sv
module pih_aggregator_chk #(
   parameter int unsigned   NB           = 8,
   parameter int unsigned   ADDR_W       = 8,
   parameter int unsigned   DATA_W       = 8,
   parameter logic [NB-1:0] PRESENT_MASK = '1,
   parameter logic [NB-1:0] DUAL_MASK    = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NB-1:0]     bank_req_l1,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              host1_irq_n,
   input logic              host2_irq_n,
   input logic [NB-1:0]     stat1_w,
   input logic [NB-1:0]     stat2_w,
   input logic [NB-1:0]     test_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (host1_irq_n && host2_irq_n && test_q == '0)
            else $error("pins or test register active in reset");
      end
   end

   // R2: a present line-1 request shows up in line-1 status next cycle
   property p_l1_follow;
      @(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat1_w & $past(bank_req_l1) & PRESENT_MASK) == ($past(bank_req_l1) & PRESENT_MASK));
   endproperty
   assert_l1_follow_R2: assert property (p_l1_follow);

   // R4: single-line banks look the same on both host lines
   property p_mirror;
      @(posedge clk) disable iff (!rst_n)
      ((stat1_w ^ stat2_w) & ~DUAL_MASK & PRESENT_MASK) == '0;
   endproperty
   assert_single_mirror_R4: assert property (p_mirror);

   // R5: absent positions never appear on the read port
   property p_absent;
      @(posedge clk) disable iff (!rst_n)
      (reg_rdata[NB-1:0] & ~PRESENT_MASK) == '0;
   endproperty
   assert_absent_zero_R5: assert property (p_absent);

   // R6 / R7: a low pin needs a requester or a test bit in the previous cycle
   property p_irq1_cause;
      @(posedge clk) disable iff (!rst_n)
      !host1_irq_n |-> ($past(|(bank_req_l1 & PRESENT_MASK)) || $past(|test_q));
   endproperty
   assert_irq1_cause_R6: assert property (p_irq1_cause);

   property p_irq2_level;
      @(posedge clk) disable iff (!rst_n)
      host2_irq_n == (stat2_w == '0);
   endproperty
   assert_irq2_level_R7: assert property (p_irq2_level);

   // R8: a test-register write lands in the register next cycle
   property p_test_write;
      @(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(3)) |=> (test_q == ($past(reg_wdata[NB-1:0]) & PRESENT_MASK));
   endproperty
   assert_test_write_R8: assert property (p_test_write);

   // R9: writes elsewhere leave the test register alone
   property p_test_hold;
      @(posedge clk) disable iff (!rst_n)
      (!(reg_wr && reg_addr == ADDR_W'(3))) |=> $stable(test_q);
   endproperty
   assert_test_hold_R9: assert property (p_test_hold);
endmodule

bind pih_aggregator pih_aggregator_chk #(
   .NB(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .PRESENT_MASK(PRESENT_MASK), .DUAL_MASK(DUAL_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bank_req_l1(bank_req_l1),
   .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .host1_irq_n(host1_irq_n), .host2_irq_n(host2_irq_n),
   .stat1_w(stat1_w), .stat2_w(stat2_w), .test_q(test_q)
);

// File: tb/sim_pih_aggregator.sv
module sim_pih_aggregator;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req1 = '0, req2 = '0;
   logic [7:0] addr = '0, wdata = '0;
   logic       wr = 1'b0;
   logic [7:0] rdata;
   logic       irq1_n, irq2_n;

   int checks = 0, fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pih_aggregator u0 (
      .clk(clk), .rst_n(rst_n),
      .bank_req_l1(req1), .bank_req_l2(req2),
      .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata), .reg_rdata(rdata),
      .host1_irq_n(irq1_n), .host2_irq_n(irq2_n)
   );

   // Entry: {req1, req2, test, expect line1, expect line2}
   // bench build: banks 6,7 absent; bank 1 single-line
   localparam logic [39:0] VEC [10] = '{
      {8'h01, 8'h00, 8'h00, 8'h01, 8'h00},   // R2
      {8'h00, 8'h04, 8'h00, 8'h00, 8'h04},   // R3
      {8'h02, 8'h00, 8'h00, 8'h02, 8'h02},   // R4 mirror
      {8'h00, 8'h02, 8'h00, 8'h00, 8'h00},   // R4 line-2 pin ignored
      {8'hC0, 8'hC0, 8'h00, 8'h00, 8'h00},   // R5
      {8'h00, 8'h00, 8'h10, 8'h10, 8'h10},   // R8
      {8'h00, 8'h00, 8'hC1, 8'h01, 8'h01},   // R5 R8
      {8'h3F, 8'h3F, 8'h00, 8'h3F, 8'h3F},   // R2 R3
      {8'h20, 8'h08, 8'h00, 8'h20, 8'h08},   // R3 independence
      {8'h00, 8'h00, 8'h00, 8'h00, 8'h00}    // R10
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr = 1'b1;
      step();
      wr = 1'b0;
   endtask

   task automatic read_reg(input logic [7:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      step();
      // R1 during and after reset
      check("R1 pins in reset", {6'b0, irq1_n, irq2_n}, 8'h03);
      rst_n = 1'b1;
      step();
      read_reg(8'h01, v); check("R1 line1 status", v, 8'h00);
      read_reg(8'h02, v); check("R1 line2 status", v, 8'h00);
      read_reg(8'h03, v); check("R1 test reg", v, 8'h00);

      for (int i = 0; i < 10; i++) begin
         req1 = VEC[i][39:32];
         req2 = VEC[i][31:24];
         write_reg(8'h03, VEC[i][23:16]);
         step();
         read_reg(8'h01, v); check($sformatf("R2 vec%0d line1", i), v, VEC[i][15:8]);
         read_reg(8'h02, v); check($sformatf("R3 vec%0d line2", i), v, VEC[i][7:0]);
         check($sformatf("R6 vec%0d pin1", i), {7'b0, irq1_n}, {7'b0, VEC[i][15:8] == 8'h00});
         check($sformatf("R7 vec%0d pin2", i), {7'b0, irq2_n}, {7'b0, VEC[i][7:0] == 8'h00});
      end

      // R8 test register read-back masks absent positions
      write_reg(8'h03, 8'hFF);
      step();
      read_reg(8'h03, v); check("R8 test readback", v, 8'h3F);
      read_reg(8'h02, v); check("R8 forced line2", v, 8'h3F);
      write_reg(8'h03, 8'h00);
      step();
      read_reg(8'h01, v); check("R10 cleared line1", v, 8'h00);
      check("R10 pins released", {6'b0, irq1_n, irq2_n}, 8'h03);

      // R9 unmapped reads and ignored writes
      read_reg(8'h00, v); check("R9 read 0x00", v, 8'h00);
      read_reg(8'h04, v); check("R9 read 0x04", v, 8'h00);
      read_reg(8'hFF, v); check("R9 read 0xFF", v, 8'h00);
      write_reg(8'h01, 8'hFF);
      write_reg(8'h07, 8'hFF);
      write_reg(8'h83, 8'hFF);
      step();
      read_reg(8'h03, v); check("R9 test reg untouched", v, 8'h00);
      read_reg(8'h01, v); check("R9 line1 untouched", v, 8'h00);
      check("R9 pins idle", {6'b0, irq1_n, irq2_n}, 8'h03);

      // R1 reset in mid-activity
      req1 = 8'h01;
      write_reg(8'h03, 8'h04);
      rst_n = 1'b0;
      #1;
      check("R1 pins forced high", {6'b0, irq1_n, irq2_n}, 8'h03);
      req1 = 8'h00;
      step();
      rst_n = 1'b1;
      step();
      read_reg(8'h03, v); check("R1 test cleared by reset", v, 8'h00);

      finish_run();
   end
endmodule